// File: doc/BRIEF.md
# Signed 128-bit to Packed Decimal Converter

The block takes a signed 128-bit two's-complement integer and turns it into a 128-bit packed-decimal word. The word holds a sign code in its lowest nibble and 31 decimal digits above it. Alongside the digits it returns a four-bit condition code. The code classifies the operand as negative, positive or zero, and it flags operands whose magnitude cannot be shown in 31 digits.

A caller pulses `start` with the operand and a preferred-sign select. The block first takes the absolute value and checks it against 10^31 - 1. It then builds the digits with an iterative shift-and-add-3 loop, one magnitude bit per clock. When it finishes it pulses `done`. For an in-range operand, `result_we` is raised with `done` and the new word appears on `result`. An out-of-range operand raises the overflow flag, writes nothing, and leaves `result` unchanged.

Top module: `bcd_from_s128`

## Requirements
- R1: On a synchronous active-high reset, `result`, `cc`, `done` and `result_we` are all zero.
- R2: For an operand with bit 127 set, the magnitude is the 128-bit two's-complement negation, the sign nibble `result[3:0]` is 4'hD, and `cc[3]` (less-than) is set.
- R3: For a non-negative operand, the sign nibble is 4'hC when `pref_sign` is 0 and 4'hF when it is 1. `cc[1]` (equal) is set for zero and `cc[2]` (greater-than) is set otherwise. Exactly one of `cc[3:1]` is set at every `done`.
- R4: When the magnitude, read as an unsigned 128-bit number, exceeds 10^31 - 1 (0x7E37BE2022_C0914B267FFFFFFF), `cc[0]` (summary overflow) is set in addition to the class bit.
- R5: On overflow, `result_we` stays low and `result` keeps the value it held before.
- R6: For an in-range operand, nibble k of `result` (bits 4k+3:4k) holds decimal digit k-1 for k = 1..31, with the least significant digit at nibble 1. `result_we` is high only in the `done` cycle, and `result` changes only then.
- R7: `done` is a one-cycle pulse. It rises 104 rising edges after the edge that accepts `start` for an in-range operand, and one edge after it on overflow.
- R8: `start` is ignored from the accepting edge until `done` has been issued. A later pulse during that time neither changes the outcome nor begins a new conversion.
- R9: `cc` changes only in a cycle where `done` is high, and holds its value between conversions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a conversion (sampled when idle) |
| operand | input | 128 | Signed two's-complement source value |
| pref_sign | input | 1 | Positive sign select: 0 gives 4'hC, 1 gives 4'hF |
| result | output | 128 | Packed decimal: sign at nibble 0, digits at nibbles 1..31 |
| result_we | output | 1 | One-cycle write enable for `result` |
| cc | output | 4 | {less-than, greater-than, equal, summary-overflow} |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions check these every cycle: `done` is a single-cycle pulse, `result_we` appears only with `done` and never with the overflow flag, `result` and `cc` change only at completion, the classification bits are one-hot, the negative class matches the 4'hD sign, and the top digit never carries out during the dabble loop. The digit values themselves can only be shown by the bench's scenarios, which compare against an arithmetic reference on every clock. The same holds for the exact boundary at 10^31 - 1 on both signs, the most negative operand, the choice of sign code, and a `start` pulse ignored mid-conversion.

// File: rtl/bcdc_pkg.sv
package bcdc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } cvt_state_e;

  localparam int CC_LT = 3;
  localparam int CC_GT = 2;
  localparam int CC_EQ = 1;
  localparam int CC_SO = 0;

  localparam logic [3:0] SGN_NEG   = 4'hD;
  localparam logic [3:0] SGN_POS_C = 4'hC;
  localparam logic [3:0] SGN_POS_F = 4'hF;
endpackage

// File: rtl/bcdc_front.sv
module bcdc_front
  import bcdc_pkg::*;
#(
  parameter int OP_W = 128,
  parameter int MAG_W = 103,
  parameter logic [OP_W-1:0] MAG_LIMIT = 128'h0000007E37BE2022_C0914B267FFFFFFF
) (
  input  logic [OP_W-1:0]  operand,
  input  logic             pref_sign,
  output logic [MAG_W-1:0] mag,
  output logic             ovf,
  output logic [3:0]       sign_nib,
  output logic [3:0]       cc_base
);
  localparam int HALF = OP_W / 2;

  logic             is_neg;
  logic [HALF-1:0]  lo_neg;
  logic [HALF-1:0]  hi_neg;
  logic [OP_W-1:0]  mag_full;
  logic             hi_gt, hi_eq, lo_gt;

  assign is_neg = operand[OP_W-1];

  // Per-half negation: the high half only takes the carry when the low half wraps to zero
  assign lo_neg = -operand[HALF-1:0];
  assign hi_neg = ~operand[OP_W-1:HALF] + {{(HALF-1){1'b0}}, (lo_neg == '0)};

  assign mag_full = is_neg ? {hi_neg, lo_neg} : operand;

  // Unsigned compare, high half decides unless equal
  assign hi_gt = mag_full[OP_W-1:HALF] > MAG_LIMIT[OP_W-1:HALF];
  assign hi_eq = mag_full[OP_W-1:HALF] == MAG_LIMIT[OP_W-1:HALF];
  assign lo_gt = mag_full[HALF-1:0] > MAG_LIMIT[HALF-1:0];
  assign ovf   = hi_gt | (hi_eq & lo_gt);

  assign mag = mag_full[MAG_W-1:0];

  always_comb begin
    cc_base = '0;
    if (is_neg) begin
      cc_base[CC_LT] = 1'b1;
      sign_nib = SGN_NEG;
    end else begin
      sign_nib = pref_sign ? SGN_POS_F : SGN_POS_C;
      if (operand == '0) cc_base[CC_EQ] = 1'b1;
      else               cc_base[CC_GT] = 1'b1;
    end
  end
endmodule

// File: rtl/bcdc_dabble.sv
module bcdc_dabble #(
  parameter int DIGITS = 31
) (
  input  logic [4*DIGITS-1:0] bcd_in,
  output logic [4*DIGITS-1:0] bcd_adj
);
  // Add 3 to every digit of 5 or more before the next doubling
  for (genvar d = 0; d < DIGITS; d++) begin : g_digit
    logic [3:0] nib;
    assign nib = bcd_in[4*d +: 4];
    assign bcd_adj[4*d +: 4] = (nib >= 4'd5) ? nib + 4'd3 : nib;
  end
endmodule

// File: rtl/bcd_from_s128.sv
module bcd_from_s128
  import bcdc_pkg::*;
#(
  parameter int OP_W = 128,
  parameter int DIGITS = 31,
  parameter int MAG_W = 103,
  parameter logic [OP_W-1:0] MAG_LIMIT = 128'h0000007E37BE2022_C0914B267FFFFFFF
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [OP_W-1:0] operand,
  input  logic            pref_sign,
  output logic [OP_W-1:0] result,
  output logic            result_we,
  output logic [3:0]      cc,
  output logic            done
);
  localparam int BCD_W = 4 * DIGITS;
  localparam int CNT_W = $clog2(MAG_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(MAG_W - 1);

  cvt_state_e       state;
  logic [CNT_W-1:0] cnt;
  logic [MAG_W-1:0] bin_q;
  logic [BCD_W-1:0] bcd_q;
  logic [BCD_W-1:0] bcd_adj;
  logic             ovf_q;
  logic [3:0]       sign_q;
  logic [3:0]       cc_pend;

  logic [MAG_W-1:0] f_mag;
  logic             f_ovf;
  logic [3:0]       f_sign;
  logic [3:0]       f_cc;

  bcdc_front #(
    .OP_W(OP_W), .MAG_W(MAG_W), .MAG_LIMIT(MAG_LIMIT)
  ) u_front (
    .operand(operand), .pref_sign(pref_sign),
    .mag(f_mag), .ovf(f_ovf), .sign_nib(f_sign), .cc_base(f_cc)
  );

  bcdc_dabble #(.DIGITS(DIGITS)) u_dabble (
    .bcd_in(bcd_q), .bcd_adj(bcd_adj)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      bin_q     <= '0;
      bcd_q     <= '0;
      ovf_q     <= 1'b0;
      sign_q    <= '0;
      cc_pend   <= '0;
      result    <= '0;
      result_we <= 1'b0;
      cc        <= '0;
      done      <= 1'b0;
    end else begin
      done      <= 1'b0;
      result_we <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          bin_q   <= f_mag;
          bcd_q   <= '0;
          cnt     <= '0;
          ovf_q   <= f_ovf;
          sign_q  <= f_sign;
          cc_pend <= f_cc | {3'b000, f_ovf};
          state   <= f_ovf ? ST_FIN : ST_RUN;
        end
        ST_RUN: begin
          bcd_q <= {bcd_adj[BCD_W-2:0], bin_q[MAG_W-1]};
          bin_q <= {bin_q[MAG_W-2:0], 1'b0};
          cnt   <= cnt + 1'b1;
          if (cnt == LAST) state <= ST_FIN;
        end
        ST_FIN: begin
          done  <= 1'b1;
          cc    <= cc_pend;
          state <= ST_IDLE;
          if (!ovf_q) begin
            result    <= {bcd_q, sign_q};
            result_we <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R6
  dabble_room_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN) |-> !bcd_adj[BCD_W-1]);
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (done && cc[CC_SO]) |-> !result_we);
  // R6
  we_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    result_we |-> done);
  // R6
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(result) |-> result_we);
  // R9
  cc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(cc) |-> done);
  // R3
  cc_class_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> ($countones(cc[3:1]) == 1));
  // R2
  neg_sign_chk: assert property (@(posedge clk) disable iff (rst)
    result_we |-> (cc[CC_LT] == (result[3:0] == SGN_NEG)));
  // R8
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && cnt != LAST) |=> (state == ST_RUN));
endmodule

// File: tb/bcd_from_s128_test.sv
module bcd_from_s128_test;
  localparam logic [127:0] LIM = 128'h0000007E37BE2022_C0914B267FFFFFFF;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [127:0] operand = '0;
  logic         pref_sign = 1'b0;
  logic [127:0] result;
  logic         result_we;
  logic [3:0]   cc;
  logic         done;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  string cur_tag = "R1";

  always #5 clk = ~clk;

  bcd_from_s128 uut (
    .clk(clk), .rst(rst), .start(start), .operand(operand), .pref_sign(pref_sign),
    .result(result), .result_we(result_we), .cc(cc), .done(done)
  );

  // Behavioural reference model
  bit           m_busy;
  int           m_cnt;
  bit           m_ovf;
  logic [127:0] m_pres, m_res;
  logic [3:0]   m_pcc, m_cc;
  bit           m_done, m_we;

  function automatic void predict(input logic [127:0] op, input logic p,
                                  output logic [127:0] r, output logic [3:0] c,
                                  output bit o);
    logic [127:0] m;
    m = op[127] ? (~op + 128'd1) : op;
    c = op[127] ? 4'b1000 : ((op == 0) ? 4'b0010 : 4'b0100);
    o = (m > LIM);
    if (o) c[0] = 1'b1;
    r = '0;
    r[3:0] = op[127] ? 4'hD : (p ? 4'hF : 4'hC);
    for (int i = 1; i < 32; i++) begin
      r[4*i +: 4] = 4'(m % 10);
      m = m / 10;
    end
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_busy = 0; m_cnt = 0; m_ovf = 0; m_pres = '0; m_res = '0;
      m_pcc = '0; m_cc = '0; m_done = 0; m_we = 0;
    end else begin
      m_done = 0;
      m_we = 0;
      if (!m_busy) begin
        if (start) begin
          predict(operand, pref_sign, m_pres, m_pcc, m_ovf);
          m_busy = 1;
          m_cnt = m_ovf ? 1 : 104;
        end
      end else begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_busy = 0;
          m_done = 1;
          m_cc = m_pcc;
          if (!m_ovf) begin
            m_we = 1;
            m_res = m_pres;
          end
        end
      end
    end
  end

  task automatic check(input bit ok, input string what, input logic [127:0] act,
                       input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", cur_tag, what, act, exp);
    end
  endtask

  // Per-clock comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      check(done == m_done, "R7 done", 128'(done), 128'(m_done));
      check(result_we == m_we, "R5/R6 result_we", 128'(result_we), 128'(m_we));
      check(cc == m_cc, "R9 cc", 128'(cc), 128'(m_cc));
      check(result == m_res, "R6 result", result, m_res);
    end
  end

  task automatic run(input logic [127:0] op, input logic p, input string tag);
    cur_tag = tag;
    @(negedge clk);
    operand = op; pref_sign = p; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (m_busy) @(negedge clk);
  endtask

  task automatic finish_up;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog expired act=%0d exp=<100000", cyc);
      finish_up();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    cur_tag = "R1";
    check(result == '0 && cc == 0 && !done && !result_we, "R1 reset outputs",
          {result_we, done, cc, result[121:0]}, '0);
    rst = 1'b0;
    @(negedge clk);
    run(128'd0, 1'b0, "R3 zero pref0");
    check(cc == 4'b0010 && result[3:0] == 4'hC, "R3 zero", 128'(cc), 128'h2);
    run(128'd0, 1'b1, "R3 zero pref1");
    check(result[3:0] == 4'hF, "R3 sign F", 128'(result[3:0]), 128'hF);
    run(128'd1, 1'b0, "R3 plus one");
    run(128'd123456789012345678901234567890, 1'b1, "R6 digits");
    run(-128'd1, 1'b0, "R2 minus one");
    check(result[7:0] == 8'h1D && cc == 4'b1000, "R2 minus one", 128'(result[7:0]), 128'h1D);
    run(-128'd98765432109876543210, 1'b0, "R2 negative");
    run(LIM, 1'b0, "R4 positive limit");
    check(cc[0] == 1'b0, "R4 limit in range", 128'(cc), 128'h4);
    run(-LIM, 1'b1, "R4 negative limit");
    run(LIM + 128'd1, 1'b0, "R5 positive over");
    check(cc == 4'b0101, "R4 over flag", 128'(cc), 128'h5);
    run(-(LIM + 128'd1), 1'b0, "R5 negative over");
    run({1'b1, 127'd0}, 1'b0, "R5 most negative");
    run({1'b0, {127{1'b1}}}, 1'b0, "R5 largest positive");
    run(128'h0000007E37BE2022_0000000000000000, 1'b0, "R4 high equal low below");
    // R8: a second start during the conversion must be ignored
    cur_tag = "R8 mid-run start";
    @(negedge clk);
    operand = 128'd4242; pref_sign = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (40) @(negedge clk);
    operand = 128'd777; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (m_busy) @(negedge clk);
    check(result[19:0] == 20'h4242C, "R8 ignored start", 128'(result[19:0]), 128'h4242C);
    repeat (5) @(negedge clk);
    check(!done && cc == 4'b0100, "R9 cc holds", 128'(cc), 128'h4);
    finish_up();
  end
endmodule